// File: doc/BRIEF.md
# SD Card SPI-Mode Power-Up Sequencer

This block sits on the host side of a four-wire SPI link to a memory card. It takes the card from power-on to the standby condition in which the card can be selected for transfers. After a `start` pulse it sends free-running clocks with chip select released. It then issues the reset command with chip select held low, which puts the card into SPI mode. Next it sends the voltage-check command and checks the echoed pattern. Finally it repeats the application-command / operating-condition pair until the card reports that it is no longer idle. The card's progress is tracked as four phases: inactive (0), idle (1), ready (2) and standby (3). The sequence ends with a held `done` or a held `error` plus a code.

The block contains three pieces: a mode-0 byte shifter with a programmable half-period divider, a command-frame builder that computes the CRC7, and a response poller. The controller states are:
- OFF (after reset)
- WAKE (power-up clocks)
- SEND (six frame bytes)
- POLL (0xFF bytes until a byte with MSB 0)
- TAIL (four trailing bytes of the voltage-check reply)
- JUDGE (one-cycle verdict)
- READY (success)
- FAULT (error)

The transitions are:
- OFF→WAKE on `start`.
- WAKE→SEND after the last power-up byte.
- SEND→POLL after byte 5.
- POLL→TAIL for the voltage check, or POLL→JUDGE for other commands, on a response.
- POLL→FAULT on timeout.
- TAIL→JUDGE after four bytes.
- JUDGE→SEND for the next command, JUDGE→READY, or JUDGE→FAULT.
- READY/FAULT→WAKE on a new `start`.

Top module: `sdspi_init_seq`

## Requirements
- R1: After `start`, chip select stays high and MOSI stays high for the power-up clocks before chip select first falls. With default parameters this is 80 SCLK rising edges, which is 74 rounded up to whole bytes.
- R2: Chip select falls only at the start of the reset command. It stays low through every frame and poll until the sequence ends, and it never changes while SCLK is high.
- R3: Each command frame is 48 bits, MSB first: `01`, a 6-bit index, a 32-bit argument, CRC7, and end bit `1`. The commands are:
  - reset: index 0, argument 0, last byte 0x95;
  - voltage check: index 8, argument 0x000001AA, last byte 0x87;
  - application prefix: index 55;
  - operating condition: index 41, argument 0x40000000.
- R4: The link uses SPI mode 0. SCLK idles low. Each SCLK high time lasts exactly `div_half` system clocks, with 0 treated as 1. MOSI never changes while SCLK is high.
- R5: After each frame the block clocks out 0xFF and takes the first byte whose MSB is 0 as the response. A response in the 8th poll byte is accepted. With no response after 8 poll bytes the block ends with error code 1.
- R6: A reset response other than 0x01 ends the sequence with error code 2. A 0x01 reply moves the phase to idle (1).
- R7: The voltage check passes only if R1 is 0x01, the echoed byte is 0xAA, and the voltage nibble is 1. On a pass the phase becomes ready (2). Otherwise the sequence ends with error code 3 and the phase stays idle.
- R8: The block repeats the application-prefix / operating-condition pair while the operating-condition reply is 0x01. A 0x00 reply gives `done`, phase standby (3), and error code 0. The phase advances only in single steps.
- R9: If `retry_limit` operating-condition attempts all return 0x01 (0 treated as 1), the sequence ends with error code 4.
- R10: A reply other than 0x00 or 0x01 to the application prefix or the operating-condition command ends the sequence with error code 5.
- R11: Out of reset, chip select is high, SCLK is low, MOSI is high, `done` and `error` are low, and the phase is inactive.
- R12: `done` and `error` are never high together. Each stays high until the next `start`, with chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins (or restarts) the sequence when idle, finished or failed |
| div_half | input | DIV_W | SCLK half-period in system clocks (0 acts as 1) |
| retry_limit | input | RETRY_W | Maximum operating-condition attempts (0 acts as 1) |
| done | output | 1 | Card reached standby |
| error | output | 1 | Sequence failed |
| err_code | output | 3 | 0 none, 1 timeout, 2 bad reset reply, 3 voltage rejected, 4 retries exhausted, 5 unexpected reply |
| card_phase | output | 2 | 0 inactive, 1 idle, 2 ready, 3 standby |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Host-to-card data |
| spi_miso | input | 1 | Card-to-host data |

## Verification
The embedded properties assume three things about the inputs:
- `start` is pulsed only while the controller is in OFF, READY or FAULT.
- `div_half` and `retry_limit` stay steady during a sequence.
- MISO changes only on falling SCLK edges or while chip select is high.

The bench honours these assumptions in three ways:
- It changes the settings only between runs.
- It waits for `done` or `error` before the next `start`.
- Its card model updates MISO only on falling SCLK edges, and it drives MISO high whenever chip select is released.

// File: rtl/sdinit_pkg.sv
`timescale 1ns/1ps
package sdinit_pkg;

    typedef enum logic [1:0] {
        CARD_INACTIVE = 2'd0,
        CARD_IDLE     = 2'd1,
        CARD_READY    = 2'd2,
        CARD_STANDBY  = 2'd3
    } card_phase_e;

    typedef enum logic [1:0] {
        SEL_RESET  = 2'd0,
        SEL_IFCOND = 2'd1,
        SEL_APPCMD = 2'd2,
        SEL_OPCOND = 2'd3
    } cmd_sel_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_TIMEOUT = 3'd1,
        ERR_RESET   = 3'd2,
        ERR_VOLT    = 3'd3,
        ERR_RETRY   = 3'd4,
        ERR_RESP    = 3'd5
    } err_e;

    localparam logic [5:0]  IDX_RESET  = 6'd0;
    localparam logic [5:0]  IDX_IFCOND = 6'd8;
    localparam logic [5:0]  IDX_APPCMD = 6'd55;
    localparam logic [5:0]  IDX_OPCOND = 6'd41;
    localparam logic [31:0] ARG_IFCOND = 32'h0000_01AA;
    localparam logic [31:0] ARG_OPCOND = 32'h4000_0000;
    localparam logic [7:0]  R1_IDLE    = 8'h01;
    localparam logic [7:0]  R1_OK      = 8'h00;
    localparam logic [7:0]  ECHO_PAT   = 8'hAA;
    localparam logic [3:0]  VOLT_OK    = 4'h1;

    // CRC7 with polynomial x^7 + x^3 + 1 over the first 40 frame bits
    function automatic logic [6:0] sd_crc7(input logic [39:0] bits);
        logic [6:0] c;
        logic       fb;
        c = 7'd0;
        for (int i = 39; i >= 0; i--) begin
            fb = bits[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdinit_tick.sv
`timescale 1ns/1ps
module sdinit_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    assign lim  = (div_half == '0) ? DIV_W'(1) : div_half;
    assign tick = (cnt_q == lim - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (restart || tick)   cnt_q <= '0;
        else                        cnt_q <= cnt_q + DIV_W'(1);
    end

    // R4: a restart always yields a full half period before the next tick
    assert_restart_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && lim != DIV_W'(1)) |=> !tick)
        else $error("tick right after restart");
endmodule

// File: rtl/sdinit_shifter.sv
`timescale 1ns/1ps
module sdinit_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_half,
    input  logic             go,
    input  logic [7:0]       tx_byte,
    input  logic             miso,
    output logic             busy,
    output logic             xdone,
    output logic [7:0]       rx_byte,
    output logic             sclk,
    output logic             mosi
);
    localparam int BITS = 8;

    logic       tick;
    logic       busy_q, sclk_q, done_q;
    logic [2:0] bit_q;
    logic [7:0] tx_q, rx_q;

    sdinit_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(go),
        .div_half(div_half), .tick(tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
            bit_q  <= '0;
            tx_q   <= 8'hFF;
            rx_q   <= 8'hFF;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (go) begin
                    busy_q <= 1'b1;
                    tx_q   <= tx_byte;
                    bit_q  <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (tick) begin
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == 3'(BITS - 1)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        tx_q  <= {tx_q[6:0], 1'b1};
                        bit_q <= bit_q + 3'd1;
                    end
                end
            end
        end
    end

    assign busy    = busy_q;
    assign xdone   = done_q;
    assign rx_byte = rx_q;
    assign sclk    = sclk_q;
    assign mosi    = busy_q ? tx_q[7] : 1'b1;

    // R4: data held steady across every high SCLK phase
    assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi))
        else $error("MOSI moved while SCLK high");

    // R4: the controller launches a byte only when the shifter is free
    assert_go_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy_q)
        else $error("launch while busy");

    // R4: SCLK returns low when a byte completes
    assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xdone |-> !sclk)
        else $error("SCLK high at byte end");
endmodule

// File: rtl/sdinit_frame.sv
`timescale 1ns/1ps
module sdinit_frame
    import sdinit_pkg::*;
(
    input  cmd_sel_e   sel,
    input  logic [2:0] byte_idx,
    output logic [7:0] byte_out
);
    logic [5:0]  idx;
    logic [31:0] arg;
    logic [6:0]  crc;
    logic [47:0] frame;

    always_comb begin
        unique case (sel)
            SEL_RESET:  begin idx = IDX_RESET;  arg = 32'd0;      end
            SEL_IFCOND: begin idx = IDX_IFCOND; arg = ARG_IFCOND; end
            SEL_APPCMD: begin idx = IDX_APPCMD; arg = 32'd0;      end
            SEL_OPCOND: begin idx = IDX_OPCOND; arg = ARG_OPCOND; end
            default:    begin idx = IDX_RESET;  arg = 32'd0;      end
        endcase
        crc   = sd_crc7({2'b01, idx, arg});
        frame = {2'b01, idx, arg, crc, 1'b1};
        unique case (byte_idx)
            3'd0:    byte_out = frame[47:40];
            3'd1:    byte_out = frame[39:32];
            3'd2:    byte_out = frame[31:24];
            3'd3:    byte_out = frame[23:16];
            3'd4:    byte_out = frame[15:8];
            3'd5:    byte_out = frame[7:0];
            default: byte_out = 8'hFF;
        endcase
    end
endmodule

// File: rtl/sdspi_init_seq.sv
`timescale 1ns/1ps
module sdspi_init_seq
    import sdinit_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int RETRY_W    = 8,
    parameter int PWRUP_CLKS = 74,
    parameter int POLL_LIMIT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DIV_W-1:0]   div_half,
    input  logic [RETRY_W-1:0] retry_limit,
    output logic               done,
    output logic               error,
    output logic [2:0]         err_code,
    output logic [1:0]         card_phase,
    output logic               spi_cs_n,
    output logic               spi_sclk,
    output logic               spi_mosi,
    input  logic               spi_miso
);
    localparam int PWRUP_BYTES = (PWRUP_CLKS + 7) / 8;
    localparam int PCW         = $clog2(PWRUP_BYTES + 1);
    localparam int POLL_W      = $clog2(POLL_LIMIT + 1);
    localparam int FRAME_LAST  = 5;
    localparam int TAIL_LAST   = 3;

    typedef enum logic [2:0] {
        ST_OFF, ST_WAKE, ST_SEND, ST_POLL, ST_TAIL, ST_JUDGE, ST_READY, ST_FAULT
    } seq_state_e;

    seq_state_e  state_q, nxt, judge_next;
    cmd_sel_e    sel_q, judge_sel;
    card_phase_e phase_q;
    err_e        err_q, judge_err;

    logic [PCW-1:0]     wake_cnt;
    logic [2:0]         byte_cnt;
    logic [POLL_W-1:0]  poll_cnt;
    logic [RETRY_W-1:0] tries, tries_inc, lim;
    logic [7:0]         r1_q;
    logic [11:0]        r7_q;
    logic               issued;

    logic       go, busy, xdone, xfer_st;
    logic [7:0] rx_byte, tx_byte, frame_byte;
    logic       wake_last, poll_last;

    sdinit_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .div_half(div_half), .go(go),
        .tx_byte(tx_byte), .miso(spi_miso), .busy(busy), .xdone(xdone),
        .rx_byte(rx_byte), .sclk(spi_sclk), .mosi(spi_mosi)
    );

    sdinit_frame u_frame (
        .sel(sel_q), .byte_idx(byte_cnt), .byte_out(frame_byte)
    );

    assign wake_last = (wake_cnt == PCW'(PWRUP_BYTES - 1));
    assign poll_last = (poll_cnt == POLL_W'(POLL_LIMIT - 1));
    assign lim       = (retry_limit == '0) ? RETRY_W'(1) : retry_limit;
    assign tries_inc = tries + RETRY_W'(1);

    // verdict on the latest response
    always_comb begin
        judge_next = ST_FAULT;
        judge_err  = ERR_RESP;
        judge_sel  = sel_q;
        unique case (sel_q)
            SEL_RESET: begin
                if (r1_q == R1_IDLE) begin
                    judge_next = ST_SEND;
                    judge_sel  = SEL_IFCOND;
                end else begin
                    judge_err = ERR_RESET;
                end
            end
            SEL_IFCOND: begin
                if (r1_q == R1_IDLE && r7_q[11:8] == VOLT_OK && r7_q[7:0] == ECHO_PAT) begin
                    judge_next = ST_SEND;
                    judge_sel  = SEL_APPCMD;
                end else begin
                    judge_err = ERR_VOLT;
                end
            end
            SEL_APPCMD: begin
                if (r1_q == R1_OK || r1_q == R1_IDLE) begin
                    judge_next = ST_SEND;
                    judge_sel  = SEL_OPCOND;
                end
            end
            SEL_OPCOND: begin
                if (r1_q == R1_OK) begin
                    judge_next = ST_READY;
                end else if (r1_q == R1_IDLE) begin
                    if (tries_inc >= lim) begin
                        judge_err = ERR_RETRY;
                    end else begin
                        judge_next = ST_SEND;
                        judge_sel  = SEL_APPCMD;
                    end
                end
            end
            default: judge_next = ST_FAULT;
        endcase
    end

    // next state
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_OFF:   if (start) nxt = ST_WAKE;
            ST_WAKE:  if (xdone && wake_last) nxt = ST_SEND;
            ST_SEND:  if (xdone && byte_cnt == 3'(FRAME_LAST)) nxt = ST_POLL;
            ST_POLL: begin
                if (xdone) begin
                    if (!rx_byte[7])
                        nxt = (sel_q == SEL_IFCOND) ? ST_TAIL : ST_JUDGE;
                    else if (poll_last)
                        nxt = ST_FAULT;
                end
            end
            ST_TAIL:  if (xdone && byte_cnt == 3'(TAIL_LAST)) nxt = ST_JUDGE;
            ST_JUDGE: nxt = judge_next;
            ST_READY: if (start) nxt = ST_WAKE;
            ST_FAULT: if (start) nxt = ST_WAKE;
            default:  nxt = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= nxt;
    end

    // sequencing data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= SEL_RESET;
            phase_q  <= CARD_INACTIVE;
            err_q    <= ERR_NONE;
            wake_cnt <= '0;
            byte_cnt <= '0;
            poll_cnt <= '0;
            tries    <= '0;
            r1_q     <= 8'hFF;
            r7_q     <= '0;
            issued   <= 1'b0;
        end else begin
            if (go)         issued <= 1'b1;
            else if (xdone) issued <= 1'b0;
            unique case (state_q)
                ST_OFF, ST_READY, ST_FAULT: begin
                    if (start) begin
                        sel_q    <= SEL_RESET;
                        phase_q  <= CARD_INACTIVE;
                        err_q    <= ERR_NONE;
                        wake_cnt <= '0;
                        byte_cnt <= '0;
                        poll_cnt <= '0;
                        tries    <= '0;
                    end
                end
                ST_WAKE: if (xdone) wake_cnt <= wake_cnt + PCW'(1);
                ST_SEND: begin
                    if (xdone) begin
                        byte_cnt <= (byte_cnt == 3'(FRAME_LAST)) ? 3'd0 : byte_cnt + 3'd1;
                        poll_cnt <= '0;
                    end
                end
                ST_POLL: begin
                    if (xdone) begin
                        if (!rx_byte[7]) begin
                            r1_q     <= rx_byte;
                            byte_cnt <= '0;
                        end else if (poll_last) begin
                            err_q <= ERR_TIMEOUT;
                        end else begin
                            poll_cnt <= poll_cnt + POLL_W'(1);
                        end
                    end
                end
                ST_TAIL: begin
                    if (xdone) begin
                        r7_q     <= {r7_q[3:0], rx_byte};
                        byte_cnt <= byte_cnt + 3'd1;
                    end
                end
                ST_JUDGE: begin
                    sel_q    <= judge_sel;
                    byte_cnt <= '0;
                    if (judge_next == ST_FAULT) begin
                        err_q <= judge_err;
                    end else begin
                        unique case (sel_q)
                            SEL_RESET:  phase_q <= CARD_IDLE;
                            SEL_IFCOND: phase_q <= CARD_READY;
                            SEL_OPCOND: if (judge_next == ST_READY) phase_q <= CARD_STANDBY;
                            default:    phase_q <= phase_q;
                        endcase
                    end
                    if (sel_q == SEL_OPCOND && judge_next == ST_SEND) tries <= tries_inc;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        xfer_st  = 1'b0;
        spi_cs_n = 1'b1;
        tx_byte  = 8'hFF;
        unique case (state_q)
            ST_WAKE:  xfer_st = 1'b1;
            ST_SEND:  begin xfer_st = 1'b1; spi_cs_n = 1'b0; tx_byte = frame_byte; end
            ST_POLL:  begin xfer_st = 1'b1; spi_cs_n = 1'b0; end
            ST_TAIL:  begin xfer_st = 1'b1; spi_cs_n = 1'b0; end
            ST_JUDGE: spi_cs_n = 1'b0;
            default:  ;
        endcase
        go         = xfer_st && !busy && !issued;
        done       = (state_q == ST_READY);
        error      = (state_q == ST_FAULT);
        err_code   = err_q;
        card_phase = phase_q;
    end

    assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error))
        else $error("done and error together");

    assert_cs_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (sel_q == SEL_RESET && phase_q == CARD_INACTIVE))
        else $error("chip select fell outside reset command");

    assert_cs_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_cs_n))
        else $error("chip select moved with SCLK high");

    assert_phase_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (card_phase != $past(card_phase)) |->
            (card_phase == 2'd0 || card_phase == $past(card_phase) + 2'd1))
        else $error("phase skipped");

    assert_standby_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> card_phase == 2'(CARD_STANDBY))
        else $error("done without standby");

    assert_timeout_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(error) && err_code == 3'(ERR_TIMEOUT)) |-> $past(state_q) == ST_POLL)
        else $error("timeout outside polling");
endmodule

// File: tb/sdspi_init_seq_test.sv
`timescale 1ns/1ps
module sdspi_init_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] div_half = 8'd2;
    logic [7:0] retry_limit = 8'd16;
    logic       done, error, spi_cs_n, spi_sclk, spi_mosi, spi_miso;
    logic [2:0] err_code;
    logic [1:0] card_phase;

    always #2.5 clk = ~clk;

    sdspi_init_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .div_half(div_half),
        .retry_limit(retry_limit), .done(done), .error(error),
        .err_code(err_code), .card_phase(card_phase), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int nchk = 0, errs = 0;

    // card configuration (written by the stimulus only)
    logic [7:0] cfg_r1_reset = 8'h01, cfg_echo = 8'hAA, cfg_r1_app = 8'h01;
    int         cfg_busy = 0, cfg_delay = 0;
    bit         cfg_silent = 0;
    logic       card_clr = 1'b0;
    int         exp_div = 2;

    // card model state
    logic [7:0]  q[$];
    int          rcnt = 0, fcnt = 0;
    logic [7:0]  in_sh = 8'h00, out_sh = 8'hFF, b, r1;
    logic [7:0]  fb [0:5];
    bit          in_frame = 0, seen_low = 0;
    int          pwr_clks = 0, cs_glitch = 0, n0 = 0, n8 = 0, n55 = 0, n41 = 0;
    int          crc_bad = 0, end_bad = 0, tail_bytes = 0;
    logic [7:0]  crc0 = 0, crc8 = 0;
    logic [31:0] arg0 = 0, arg8 = 0, arg;
    logic [5:0]  idx;

    function automatic logic [6:0] ref_crc(input logic [39:0] v);
        logic [6:0] c = 7'd0;
        for (int i = 39; i >= 0; i--) begin
            logic f = v[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (f ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    assign spi_miso = spi_cs_n ? 1'b1 : out_sh[7];

    always @(posedge spi_sclk or negedge spi_sclk or posedge card_clr) begin
        if (card_clr) begin
            q.delete();
            rcnt = 0; fcnt = 0; in_sh = 0; out_sh = 8'hFF; in_frame = 0; seen_low = 0;
            pwr_clks = 0; cs_glitch = 0; n0 = 0; n8 = 0; n55 = 0; n41 = 0;
            crc_bad = 0; end_bad = 0; tail_bytes = 0; crc0 = 0; crc8 = 0; arg0 = 0; arg8 = 0;
        end else if (spi_sclk) begin
            if (spi_cs_n) begin
                rcnt = 0;
                if (!seen_low) pwr_clks++;
                else cs_glitch++;
                if (spi_mosi !== 1'b1) cs_glitch++;
            end else begin
                seen_low = 1;
                in_sh = {in_sh[6:0], spi_mosi};
                rcnt++;
                if (rcnt == 8) begin
                    rcnt = 0;
                    b = in_sh;
                    if (!in_frame) begin
                        if (b[7:6] == 2'b01) begin in_frame = 1; fb[0] = b; fcnt = 1; end
                        else tail_bytes++;
                    end else begin
                        fb[fcnt] = b; fcnt++;
                        if (fcnt == 6) begin
                            in_frame = 0; tail_bytes = 0;
                            idx = fb[0][5:0];
                            arg = {fb[1], fb[2], fb[3], fb[4]};
                            if (ref_crc({fb[0], arg}) != fb[5][7:1]) crc_bad++;
                            if (!fb[5][0]) end_bad++;
                            case (idx)
                                6'd0:  begin n0++; crc0 = fb[5]; arg0 = arg; r1 = cfg_r1_reset; end
                                6'd8:  begin n8++; crc8 = fb[5]; arg8 = arg; r1 = 8'h01; end
                                6'd55: begin n55++; r1 = cfg_r1_app; end
                                6'd41: begin n41++; r1 = (n41 <= cfg_busy) ? 8'h01 : 8'h00;
                                             if (arg != 32'h4000_0000) crc_bad++; end
                                default: r1 = 8'h04;
                            endcase
                            if (!cfg_silent) begin
                                for (int k = 0; k < cfg_delay; k++) q.push_back(8'hFF);
                                q.push_back(r1);
                                if (idx == 6'd8) begin
                                    q.push_back(8'h00); q.push_back(8'h00);
                                    q.push_back(8'h01); q.push_back(cfg_echo);
                                end
                            end
                        end
                    end
                end
            end
        end else begin
            if (!spi_cs_n) begin
                if (rcnt == 0) out_sh = (q.size() > 0) ? q.pop_front() : 8'hFF;
                else           out_sh = {out_sh[6:0], 1'b1};
            end
        end
    end

    // per-clock reference of the link timing
    int   ck_n = 0, ck_err = 0, hi_len = 0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_sclk && prev_sclk) begin
                ck_n++;
                if (spi_mosi !== prev_mosi) begin
                    ck_err++; $display("FAIL R4 mosi hold: got %0b expected %0b", spi_mosi, prev_mosi);
                end
            end
            if (!spi_sclk && prev_sclk) begin
                ck_n++;
                if (hi_len != exp_div) begin
                    ck_err++; $display("FAIL R4 high time: got %0d expected %0d", hi_len, exp_div);
                end
            end
            if (done && error) begin
                ck_err++; $display("FAIL R12 exclusive: got 1 expected 0");
            end
            hi_len = spi_sclk ? (prev_sclk ? hi_len + 1 : 1) : 0;
        end
        prev_sclk = spi_sclk;
        prev_mosi = spi_mosi;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input int div, input int lim);
        int waited = 0;
        div_half = 8'(div); retry_limit = 8'(lim); exp_div = (div == 0) ? 1 : div;
        card_clr = 1'b1; #1; card_clr = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!(done || error) && waited < 25000) begin
            @(negedge clk); waited++;
        end
        chk("watchdog", longint'(waited >= 25000), 0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 cs_n", spi_cs_n, 1);
        chk("R11 sclk", spi_sclk, 0);
        chk("R11 mosi", spi_mosi, 1);
        chk("R11 done", done, 0);
        chk("R11 error", error, 0);
        chk("R11 phase", card_phase, 0);

        // nominal: two busy replies, one filler byte before each reply
        cfg_busy = 2; cfg_delay = 1;
        run_case(2, 16);
        chk("R8 done", done, 1);
        chk("R8 err_code", err_code, 0);
        chk("R8 phase standby", card_phase, 3);
        chk("R8 opcond count", n41, 3);
        chk("R8 appcmd count", n55, 3);
        chk("R1 power-up clocks", pwr_clks, 80);
        chk("R2 cs steady", cs_glitch, 0);
        chk("R3 reset crc byte", crc0, 8'h95);
        chk("R3 reset arg", arg0, 0);
        chk("R3 ifcond crc byte", crc8, 8'h87);
        chk("R3 ifcond arg", arg8, 32'h1AA);
        chk("R3 crc/arg errors", crc_bad, 0);
        chk("R3 end bits", end_bad, 0);
        chk("R12 cs released", spi_cs_n, 1);
        repeat (50) @(negedge clk);
        chk("R12 done held", done, 1);

        // reset reply wrong
        cfg_busy = 0; cfg_delay = 0; cfg_r1_reset = 8'h00;
        run_case(2, 16);
        chk("R6 error", error, 1);
        chk("R6 code", err_code, 2);
        chk("R6 phase", card_phase, 0);
        chk("R6 no ifcond", n8, 0);
        chk("R12 done low", done, 0);
        cfg_r1_reset = 8'h01;

        // voltage pattern rejected
        cfg_echo = 8'h55;
        run_case(2, 16);
        chk("R7 code", err_code, 3);
        chk("R7 phase idle", card_phase, 1);
        cfg_echo = 8'hAA;

        // silent card
        cfg_silent = 1;
        run_case(2, 16);
        chk("R5 timeout code", err_code, 1);
        chk("R5 poll bytes", tail_bytes, 8);
        cfg_silent = 0;

        // reply in the last poll byte, slower clock
        cfg_delay = 7;
        run_case(3, 16);
        chk("R5 late reply done", done, 1);
        chk("R5 late reply phase", card_phase, 3);
        cfg_delay = 0;

        // never leaves idle, limit 3
        cfg_busy = 255;
        run_case(1, 3);
        chk("R9 code", err_code, 4);
        chk("R9 attempts", n41, 3);
        chk("R7 phase ready", card_phase, 2);
        cfg_busy = 0;

        // bad prefix reply
        cfg_r1_app = 8'h04;
        run_case(2, 16);
        chk("R10 code", err_code, 5);
        chk("R10 no opcond", n41, 0);
        cfg_r1_app = 8'h01;

        chk("R4 timing errors", ck_err, 0);
        $display("Result: errors=%0d of %0d checks", errs + ck_err, nchk + ck_n);
        $finish;
    end
endmodule